// File: doc/BRIEF.md
# Time-Stamp Bucket Sorter

This block takes detector hit words that arrive in no particular time order and hands them on grouped by crossing number. Each input word carries a crossing number in its upper half and a hit payload in its lower half. The block splits the word into these two fields. It then stores the payload in a static RAM at an address built from the low bits of the crossing number and a per-bucket fill count. The addressing alone does the sorting: there are no comparators between hits, and storage grows linearly with the number of hits held.

A drain process walks the crossing numbers upward, one at a time. It releases a bucket only once the newest accepted crossing number is at least a latency window ahead of it. It then reads every stored hit of that crossing back to back, marks the final one, and frees the bucket for reuse. Crossings that received no hits produce no output. Hits the block cannot hold raise a sticky error flag. These are hits for a full bucket, hits that are too late, and hits that are too far ahead.

Top module: `hs_sorter`

## Requirements
- R1: An input word is split as crossing number = bits [31:16] and hit payload = bits [15:0]. Each emitted hit carries its payload on `out_hit` and its crossing number on `out_bco`.
- R2: All accepted hits of one crossing number leave on consecutive cycles, in the order they arrived, with the same `out_bco`.
- R3: Groups leave in increasing crossing-number order, whatever the arrival order.
- R4: `out_last` is high on the final hit of each group and on no other output cycle.
- R5: A crossing number with no accepted hits produces no output cycle.
- R6: Each bucket holds at most 2**SLOT_BITS hits (4 by default). Further hits for that crossing are dropped and `ovf_flag` goes high and stays high until reset.
- R7: The group for crossing k is not released before a hit with crossing number at least k+LAT (LAT = 2 by default) has been accepted.
- R8: A hit is dropped and sets `ovf_flag` when its crossing number lies outside the acceptance window. The window runs from the next crossing still to be drained, over 2**BKT_BITS − 1 crossings (0 to 6 ahead by default). This covers hits older than that crossing and hits 7 or more ahead.
- R9: After reset there is no output, `ovf_flag` is low, and the next crossing to be drained is 0.
- R10: Once a bucket is drained it is empty and serves crossing k + 2**BKT_BITS with no stale hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input word present this cycle |
| in_word | input | 32 | Crossing number [31:16], hit payload [15:0] |
| out_valid | output | 1 | Output hit present this cycle |
| out_hit | output | 16 | Hit payload |
| out_bco | output | 16 | Crossing number of the current group |
| out_last | output | 1 | Final hit of the current group |
| ovf_flag | output | 1 | Sticky flag: a hit was dropped |

## Verification
The assertions check several properties on every cycle:
- the drop flag never falls without a reset;
- `out_last` never appears without `out_valid`;
- a group never breaks up or changes crossing number before its last hit;
- no bucket is written past its capacity, or in the same cycle it is freed;
- a bucket is read only while the newest crossing is at least LAT ahead;
- the newest crossing stays inside the acceptance window.

Only the bench scenarios can show that the data is right. They confirm that payloads come back in arrival order within a group, that whole groups come out in increasing crossing order, and that empty crossings are skipped. They also confirm that late, far-ahead and excess hits never appear at the output, and that a reused bucket holds only its new crossing's hits.

// File: rtl/hs_pkg.sv
// Shared types for the time-stamp bucket sorter.
package hs_pkg;

    // Drain sequencer state.
    typedef enum logic [0:0] {
        DR_IDLE = 1'b0,
        DR_READ = 1'b1
    } drain_state_t;

endpackage

// File: rtl/hs_ingress.sv
// Input control and field split for the bucket sorter.
// Splits each word into crossing number and payload. Checks the crossing
// against the acceptance window and the target bucket's fill state, then
// issues a write or drops the hit. Keeps the newest accepted crossing and the
// sticky drop flag.
// Assumes: rd_base is the next crossing still to be drained (including one
// being started this cycle); cand_full refers to cand_bkt.
module hs_ingress #(
    parameter int BCO_W    = 16,
    parameter int HIT_W    = 16,
    parameter int BKT_BITS = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic [BCO_W+HIT_W-1:0]   in_word,
    input  logic [BCO_W-1:0]         rd_base,
    input  logic                     cand_full,
    output logic [BKT_BITS-1:0]      cand_bkt,
    output logic                     wr_en,
    output logic [HIT_W-1:0]         wr_hit,
    output logic [BCO_W-1:0]         newest,
    output logic                     ovf
);
    localparam int              NBKT   = 1 << BKT_BITS;
    localparam int              WORD_W = BCO_W + HIT_W;
    localparam logic [BCO_W-1:0] WIN   = BCO_W'(NBKT - 1);

    logic [BCO_W-1:0] hit_bco;
    logic [BCO_W-1:0] hit_off;
    logic [BCO_W-1:0] new_off;
    logic             in_window;
    logic             drop;

    // Field split, window test and accept decision.
    always_comb begin
        hit_bco   = in_word[WORD_W-1:HIT_W];
        wr_hit    = in_word[HIT_W-1:0];
        cand_bkt  = hit_bco[BKT_BITS-1:0];
        hit_off   = hit_bco - rd_base;
        new_off   = newest - rd_base;
        in_window = hit_off < WIN;
        wr_en     = in_valid && in_window && !cand_full;
        drop      = in_valid && !wr_en;
    end

    // Newest accepted crossing and sticky drop flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            newest <= '0;
            ovf    <= 1'b0;
        end else begin
            if (drop)
                ovf <= 1'b1;
            if (wr_en && (hit_off > new_off))
                newest <= hit_bco;
        end
    end

    // R6/R8: once a hit has been dropped the flag stays set.
    p_ovf_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> ovf);

    // R7: the newest crossing never runs outside the acceptance window.
    p_newest_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (newest - rd_base) < WIN);

endmodule

// File: rtl/hs_store.sv
// Bucket storage for the sorter: one fill counter per bucket plus a
// static RAM addressed {bucket, slot}.
// A write lands at the slot given by the bucket's current fill count. A clear
// empties one bucket's counter. Reads are registered, with one cycle of latency.
// Assumes: the writer never targets a full bucket or the bucket being cleared.
module hs_store #(
    parameter int BKT_BITS  = 3,
    parameter int SLOT_BITS = 2,
    parameter int HIT_W     = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [BKT_BITS-1:0]   wr_bkt,
    input  logic [HIT_W-1:0]      wr_hit,
    output logic                  wr_full,
    input  logic                  clr_en,
    input  logic [BKT_BITS-1:0]   cnt_bkt,
    output logic [SLOT_BITS:0]    cnt_out,
    input  logic                  rd_en,
    input  logic [BKT_BITS-1:0]   rd_bkt,
    input  logic [SLOT_BITS-1:0]  rd_slot,
    output logic [HIT_W-1:0]      rd_data
);
    localparam int NBKT   = 1 << BKT_BITS;
    localparam int DEPTH  = 1 << SLOT_BITS;
    localparam int CNT_W  = SLOT_BITS + 1;
    localparam int WORDS  = NBKT * DEPTH;
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

    logic [CNT_W-1:0] fill [NBKT];
    logic [HIT_W-1:0] mem  [WORDS];
    logic [CNT_W-1:0] wr_fill;

    // Fill lookups for the writer and the drain.
    always_comb begin
        wr_fill = fill[wr_bkt];
        wr_full = (wr_fill == CNT_FULL);
        cnt_out = fill[cnt_bkt];
    end

    // Per-bucket fill counters: clear on drain start, count up on write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int b = 0; b < NBKT; b++)
                fill[b] <= '0;
        end else begin
            for (int b = 0; b < NBKT; b++) begin
                if (clr_en && (cnt_bkt == BKT_BITS'(b)))
                    fill[b] <= '0;
                else if (wr_en && (wr_bkt == BKT_BITS'(b)))
                    fill[b] <= fill[b] + CNT_W'(1);
            end
        end
    end

    // RAM write port.
    always_ff @(posedge clk) begin
        if (wr_en)
            mem[{wr_bkt, wr_fill[SLOT_BITS-1:0]}] <= wr_hit;
    end

    // RAM registered read port.
    always_ff @(posedge clk) begin
        if (rd_en)
            rd_data <= mem[{rd_bkt, rd_slot}];
    end

    // R6: no write is ever issued to a bucket that is already full.
    p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (fill[wr_bkt] < CNT_FULL));

    // R10: a bucket being freed is never written in the same cycle.
    p_clear_apart_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && clr_en) |-> (wr_bkt != cnt_bkt));

endmodule

// File: rtl/hs_drain.sv
// Drain sequencer for the sorter.
// Walks crossing numbers upward from 0. A bucket is started once the newest
// accepted crossing is LAT or more ahead. Starting a bucket latches its count,
// frees its counter and advances the read pointer. A non-empty bucket is then
// read one slot per cycle. The output tags are registered to match the
// RAM's one-cycle read latency.
// Assumes: LAT >= 1 and LAT <= 2**BKT_BITS - 2.
module hs_drain
    import hs_pkg::*;
#(
    parameter int BCO_W     = 16,
    parameter int BKT_BITS  = 3,
    parameter int SLOT_BITS = 2,
    parameter int LAT       = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [BCO_W-1:0]      newest,
    input  logic [SLOT_BITS:0]    cnt_in,
    output logic [BKT_BITS-1:0]   cnt_bkt,
    output logic                  clr_en,
    output logic [BCO_W-1:0]      rd_base,
    output logic                  rd_en,
    output logic [BKT_BITS-1:0]   rd_bkt,
    output logic [SLOT_BITS-1:0]  rd_slot,
    output logic                  out_valid,
    output logic [BCO_W-1:0]      out_bco,
    output logic                  out_last
);
    localparam int               CNT_W = SLOT_BITS + 1;
    localparam logic [BCO_W-1:0] LAT_V = BCO_W'(LAT);

    drain_state_t           st;
    logic [BCO_W-1:0]       rd_bco;
    logic [BCO_W-1:0]       d_bco;
    logic [BKT_BITS-1:0]    d_bkt;
    logic [CNT_W-1:0]       d_cnt;
    logic [SLOT_BITS-1:0]   d_slot;
    logic                   start;
    logic                   issue_last;

    // Start decision, read address and last-slot detect.
    always_comb begin
        start      = (st == DR_IDLE) && ((newest - rd_bco) >= LAT_V);
        cnt_bkt    = rd_bco[BKT_BITS-1:0];
        clr_en     = start;
        rd_base    = rd_bco + {{(BCO_W-1){1'b0}}, start};
        rd_en      = (st == DR_READ);
        rd_bkt     = d_bkt;
        rd_slot    = d_slot;
        issue_last = rd_en && (({1'b0, d_slot} + CNT_W'(1)) == d_cnt);
    end

    // Sequencer: latch a bucket on start, step slots while reading.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= DR_IDLE;
            rd_bco <= '0;
            d_bco  <= '0;
            d_bkt  <= '0;
            d_cnt  <= '0;
            d_slot <= '0;
        end else if (start) begin
            rd_bco <= rd_bco + BCO_W'(1);
            d_bco  <= rd_bco;
            d_bkt  <= cnt_bkt;
            d_cnt  <= cnt_in;
            d_slot <= '0;
            st     <= (cnt_in != '0) ? DR_READ : DR_IDLE;
        end else if (st == DR_READ) begin
            d_slot <= d_slot + 1'b1;
            if (issue_last)
                st <= DR_IDLE;
        end
    end

    // Output tags aligned with the registered RAM read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_last  <= 1'b0;
            out_bco   <= '0;
        end else begin
            out_valid <= rd_en;
            out_last  <= issue_last;
            out_bco   <= d_bco;
        end
    end

    // R4: the group end marker only appears on a valid output.
    p_last_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid);

    // R2: a group continues on the next cycle with the same crossing.
    p_group_contig_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_last) |=> (out_valid && (out_bco == $past(out_bco))));

    // R7: a bucket is read only while the newest crossing is LAT ahead.
    p_release_lag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> ((newest - d_bco) >= LAT_V));

endmodule

// File: rtl/hs_sorter.sv
// Time-stamp bucket sorter, top level.
// Connects the input stage, the bucket storage and the drain sequencer.
// Hits arriving in any crossing order leave grouped by crossing number, in
// increasing order, with the final hit of each group marked.
// Assumes: LAT between 1 and 2**BKT_BITS - 2.
module hs_sorter #(
    parameter int BCO_W     = 16,
    parameter int HIT_W     = 16,
    parameter int BKT_BITS  = 3,
    parameter int SLOT_BITS = 2,
    parameter int LAT       = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [BCO_W+HIT_W-1:0]  in_word,
    output logic                    out_valid,
    output logic [HIT_W-1:0]        out_hit,
    output logic [BCO_W-1:0]        out_bco,
    output logic                    out_last,
    output logic                    ovf_flag
);
    logic [BKT_BITS-1:0]  cand_bkt;
    logic                 cand_full;
    logic                 wr_en;
    logic [HIT_W-1:0]     wr_hit;
    logic [BCO_W-1:0]     newest;
    logic [BCO_W-1:0]     rd_base;
    logic [BKT_BITS-1:0]  cnt_bkt;
    logic [SLOT_BITS:0]   cnt_val;
    logic                 clr_en;
    logic                 rd_en;
    logic [BKT_BITS-1:0]  rd_bkt;
    logic [SLOT_BITS-1:0] rd_slot;

    hs_ingress #(
        .BCO_W(BCO_W), .HIT_W(HIT_W), .BKT_BITS(BKT_BITS)
    ) u_ingress (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
        .rd_base(rd_base), .cand_full(cand_full), .cand_bkt(cand_bkt),
        .wr_en(wr_en), .wr_hit(wr_hit), .newest(newest), .ovf(ovf_flag)
    );

    hs_store #(
        .BKT_BITS(BKT_BITS), .SLOT_BITS(SLOT_BITS), .HIT_W(HIT_W)
    ) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_bkt(cand_bkt),
        .wr_hit(wr_hit), .wr_full(cand_full), .clr_en(clr_en),
        .cnt_bkt(cnt_bkt), .cnt_out(cnt_val), .rd_en(rd_en),
        .rd_bkt(rd_bkt), .rd_slot(rd_slot), .rd_data(out_hit)
    );

    hs_drain #(
        .BCO_W(BCO_W), .BKT_BITS(BKT_BITS), .SLOT_BITS(SLOT_BITS), .LAT(LAT)
    ) u_drain (
        .clk(clk), .rst_n(rst_n), .newest(newest), .cnt_in(cnt_val),
        .cnt_bkt(cnt_bkt), .clr_en(clr_en), .rd_base(rd_base),
        .rd_en(rd_en), .rd_bkt(rd_bkt), .rd_slot(rd_slot),
        .out_valid(out_valid), .out_bco(out_bco), .out_last(out_last)
    );

endmodule

// File: tb/hs_sorter_tb.sv
module hs_sorter_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_word = '0;
    logic        out_valid;
    logic [15:0] out_hit;
    logic [15:0] out_bco;
    logic        out_last;
    logic        ovf_flag;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    // Captured output stream: {last, bco, hit}.
    logic [32:0] cap [0:255];
    int          n_cap = 0;
    logic [32:0] exp_w [0:15];
    int          n_exp = 0;
    int          base  = 0;

    always #4 clk = ~clk;   // 125 MHz

    hs_sorter u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
        .out_valid(out_valid), .out_hit(out_hit), .out_bco(out_bco),
        .out_last(out_last), .ovf_flag(ovf_flag)
    );

    // Output monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_n && out_valid && n_cap < 256) begin
            cap[n_cap] = {out_last, out_bco, out_hit};
            n_cap = n_cap + 1;
        end
    end

    task automatic check(input string req, input logic [32:0] act, input logic [32:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, expv);
        end
    endtask

    task automatic push(input logic [15:0] bco, input logic [15:0] hit);
        @(negedge clk);
        in_valid = 1'b1;
        in_word  = {bco, hit};
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_hit(input logic [15:0] bco, input logic [15:0] hit, input logic last);
        exp_w[n_exp] = {last, bco, hit};
        n_exp++;
    endtask

    task automatic open_window();
        base  = n_cap;
        n_exp = 0;
    endtask

    // Compare the stream captured since open_window against the expectation.
    task automatic compare_stream(input string req);
        check({req, " count"}, 33'(n_cap - base), 33'(n_exp));
        for (int i = 0; i < n_exp; i++)
            if (base + i < n_cap)
                check(req, cap[base + i], exp_w[i]);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        in_valid = 1'b0;
        idle(3);
        rst_n = 1'b1;
    endtask

    // R9: reset state.
    task automatic t_reset();
        do_reset();
        check("R9 out_valid", 33'(out_valid), 33'd0);
        check("R9 ovf_flag", 33'(ovf_flag), 33'd0);
    endtask

    // R1 R2 R3 R7: out-of-order hits, held until the latency window passes.
    task automatic t_basic();
        open_window();
        push(16'd1, 16'hA001);
        push(16'd0, 16'hB000);
        push(16'd1, 16'hC001);
        push(16'd0, 16'hD000);
        idle(6);
        check("R7 held before release", 33'(n_cap - base), 33'd0);
        push(16'd3, 16'hE003);
        idle(20);
        expect_hit(16'd0, 16'hB000, 1'b0);
        expect_hit(16'd0, 16'hD000, 1'b1);
        expect_hit(16'd1, 16'hA001, 1'b0);
        expect_hit(16'd1, 16'hC001, 1'b1);
        compare_stream("R2 R3 R1 basic");
    endtask

    // R5 R4: empty crossing 2 skipped, single-hit groups marked last.
    task automatic t_skip_empty();
        open_window();
        push(16'd4, 16'h4444);
        push(16'd6, 16'h6666);
        idle(20);
        expect_hit(16'd3, 16'hE003, 1'b1);
        expect_hit(16'd4, 16'h4444, 1'b1);
        compare_stream("R5 R4 skip");
        check("R6 no drop yet", 33'(ovf_flag), 33'd0);
    endtask

    // R6: fifth hit to a bucket of four is dropped and flagged.
    task automatic t_overflow();
        open_window();
        for (int i = 0; i < 5; i++)
            push(16'd5, 16'h5000 + 16'(i));
        idle(2);
        check("R6 ovf set", 33'(ovf_flag), 33'd1);
        push(16'd7, 16'h7777);
        idle(20);
        for (int i = 0; i < 4; i++)
            expect_hit(16'd5, 16'h5000 + 16'(i), i == 3);
        compare_stream("R6 R4 full bucket");
        check("R6 ovf sticky", 33'(ovf_flag), 33'd1);
    endtask

    // R8 R10: late and far hits dropped; bucket 0 reused for crossing 8.
    task automatic t_window();
        open_window();
        push(16'd2, 16'hDEAD);
        push(16'd20, 16'hFA20);
        push(16'd8, 16'h8888);
        push(16'd12, 16'hCCCC);
        idle(30);
        expect_hit(16'd6, 16'h6666, 1'b1);
        expect_hit(16'd7, 16'h7777, 1'b1);
        expect_hit(16'd8, 16'h8888, 1'b1);
        compare_stream("R8 R10 window");
    endtask

    // R9: reset clears the flag and restarts draining at crossing 0.
    task automatic t_restart();
        do_reset();
        check("R9 ovf cleared", 33'(ovf_flag), 33'd0);
        open_window();
        push(16'd0, 16'h0F0F);
        push(16'd2, 16'h2222);
        idle(15);
        expect_hit(16'd0, 16'h0F0F, 1'b1);
        compare_stream("R9 restart");
    endtask

    initial begin
        t_reset();
        t_basic();
        t_skip_empty();
        t_overflow();
        t_window();
        t_restart();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

endmodule